// File: doc/BRIEF.md
# Shaped On-Off Keying Amplitude Ramp

This block makes an amplitude scale factor that rises and falls by itself, and it multiplies an incoming signed waveform sample by that factor. A keying input sets the direction. While the key is high the factor climbs toward a programmable ceiling. While it is low the factor falls toward zero. The edges of a keyed carrier are therefore shaped and not hard-switched.

The pace of the ramp comes from a loadable down-counter. Each time the counter reaches its terminal count it reloads from a ramp-rate register and fires one step tick. Some events also force a reload before the terminal count: a change of the key, an update strobe while the load-timer bit is set, and the moment ramping becomes active. Bits [15:14] of the amplitude register select the step size. The ten low bits of the same register set the ceiling.

Top module: `osk_amp_ramp`

## Requirements
- R1: Ramping is active only when both `osk_en_i` and `auto_en_i` are 1. While inactive, `scale_o` keeps its value and the rate timer keeps its count.
- R2: On a step tick with `key_i` low, `scale_o` falls by the step size. It stops at 0 and never wraps.
- R3: On a step tick with `key_i` high, `scale_o` becomes the smaller of (scale + step) and the ceiling `amp_reg_i[9:0]`.
- R4: The step size is 1, 2, 4 or 8 for `amp_reg_i[15:14]` equal to 00, 01, 10 or 11.
- R5: With no forced reload and a rate value R of 2 or more, one tick occurs every R clocks. A rate value of 0 or 1 gives one tick every clock.
- R6: A change of `key_i` against its value in the previous clock reloads the timer from `rate_i`. No tick occurs in that clock.
- R7: `io_update_i` reloads the timer, with no tick in that clock, only while `load_en_i` is 1. When `load_en_i` is 0 the strobe has no effect.
- R8: The clock in which ramping goes from inactive to active reloads the timer and produces no tick.
- R9: `sample_o` equals the arithmetic right shift by 10 of (`sample_i` × `scale_o`), with the sample taken as 14-bit two's complement. A scale of 0 gives an output of 0.
- R10: After reset `scale_o` is 0 and the timer count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 1 | Keying input: 1 ramps up, 0 ramps down |
| io_update_i | input | 1 | Register update strobe |
| osk_en_i | input | 1 | Amplitude keying enable |
| auto_en_i | input | 1 | Automatic ramp enable |
| load_en_i | input | 1 | Lets the update strobe reload the timer |
| amp_reg_i | input | 16 | [15:14] step code, [9:0] ceiling |
| rate_i | input | 8 | Ramp-rate timer reload value |
| sample_i | input | 14 | Signed waveform sample |
| scale_o | output | 10 | Current scale factor |
| sample_o | output | 14 | Scaled signed sample |

## Verification
A forced reload can fall in the same clock as the timer's terminal count. In that case the reload must win, and no step is taken. The bench provokes this with key toggles and update strobes at short rate values, so terminal counts often coincide with them. It also toggles the enables at random. A cycle-accurate bench model, built from the requirements, predicts the scale value after every clock, so a tick that leaks through or goes missing shows up as a scale mismatch.

// File: rtl/osk_pkg.sv
package osk_pkg;
  localparam int SCALE_W  = 10;
  localparam int RATE_W   = 8;
  localparam int AMP_W    = 16;
  localparam int SAMPLE_W = 14;

  typedef enum logic [1:0] {
    STEP_1 = 2'b00,
    STEP_2 = 2'b01,
    STEP_4 = 2'b10,
    STEP_8 = 2'b11
  } step_code_e;

  function automatic logic [SCALE_W-1:0] step_of(input step_code_e code);
    return SCALE_W'(1) << code;
  endfunction
endpackage

// File: rtl/osk_rate_timer.sv
module osk_rate_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              force_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              term;

  assign term = (cnt_q <= RATE_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    tick_o = 1'b0;
    if (active_i) begin
      if (force_i) begin
        cnt_d = rate_i;
      end else if (term) begin
        cnt_d  = rate_i;
        tick_o = 1'b1;
      end else begin
        cnt_d = cnt_q - RATE_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_FROZEN_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(cnt_q)); // R1
  AST_FORCED_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && force_i |=> cnt_q == $past(rate_i)); // R6
  AST_NO_TICK_ON_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> !tick_o); // R7
endmodule

// File: rtl/osk_scale_ctr.sv
module osk_scale_ctr
  import osk_pkg::*;
#(
  parameter int SW = SCALE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          tick_i,
  input  logic          up_i,
  input  step_code_e    step_code_i,
  input  logic [SW-1:0] ceil_i,
  output logic [SW-1:0] scale_o
);
  logic [SW-1:0] scale_q, scale_d, step;
  logic [SW:0]   sum;

  assign step = SW'(step_of(step_code_i));
  assign sum  = {1'b0, scale_q} + {1'b0, step};

  always_comb begin
    scale_d = scale_q;
    if (tick_i) begin
      if (up_i) scale_d = (sum > {1'b0, ceil_i}) ? ceil_i : sum[SW-1:0];
      else      scale_d = (scale_q > step) ? scale_q - step : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scale_q <= '0;
    else         scale_q <= scale_d;
  end

  assign scale_o = scale_q;

  AST_HOLD_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(scale_q)); // R1
  AST_FLOOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !up_i && scale_q <= step |=> scale_q == '0); // R2
  AST_CEIL_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && up_i |=> scale_q <= $past(ceil_i)); // R3
  AST_STEP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && up_i && sum <= {1'b0, ceil_i} |=> scale_q - $past(scale_q) == $past(step)); // R4
endmodule

// File: rtl/osk_sample_mul.sv
module osk_sample_mul #(
  parameter int SAMPLE_W = 14,
  parameter int SW       = 10
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [SW-1:0]       scale_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam int PROD_W = SAMPLE_W + SW + 1;
  logic signed [PROD_W-1:0] prod;

  assign prod     = PROD_W'(sample_i) * $signed({1'b0, scale_i});
  assign sample_o = prod[SAMPLE_W+SW-1:SW];
endmodule

// File: rtl/osk_amp_ramp.sv
module osk_amp_ramp
  import osk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                key_i,
  input  logic                io_update_i,
  input  logic                osk_en_i,
  input  logic                auto_en_i,
  input  logic                load_en_i,
  input  logic [AMP_W-1:0]    amp_reg_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SCALE_W-1:0]  scale_o,
  output logic [SAMPLE_W-1:0] sample_o
);
  logic key_q, active_q, active, force_ld, tick;

  assign active   = osk_en_i & auto_en_i;
  assign force_ld = (key_i ^ key_q) | (io_update_i & load_en_i) | (active & ~active_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      key_q    <= key_i;
      active_q <= active;
    end
  end

  osk_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .force_i (force_ld),
    .rate_i  (rate_i),
    .tick_o  (tick)
  );

  osk_scale_ctr #(.SW(SCALE_W)) u_scale (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .tick_i     (tick),
    .up_i       (key_i),
    .step_code_i(step_code_e'(amp_reg_i[AMP_W-1:AMP_W-2])),
    .ceil_i     (amp_reg_i[SCALE_W-1:0]),
    .scale_o    (scale_o)
  );

  osk_sample_mul #(.SAMPLE_W(SAMPLE_W), .SW(SCALE_W)) u_mul (
    .sample_i(sample_i),
    .scale_i (scale_o),
    .sample_o(sample_o)
  );

  AST_ZERO_SCALE_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scale_o == '0 |-> sample_o == '0); // R9
  AST_ACTIVATION_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !active_q |=> $stable(scale_o)); // R8
endmodule

// File: tb/osk_amp_ramp_tb.sv
module osk_amp_ramp_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        key_i = 1'b0, io_update_i = 1'b0, osk_en_i = 1'b0, auto_en_i = 1'b0, load_en_i = 1'b0;
  logic [15:0] amp_reg_i = '0;
  logic [7:0]  rate_i = '0;
  logic [13:0] sample_i = '0;
  logic [9:0]  scale_o;
  logic [13:0] sample_o;

  int n_vec = 0, n_bad = 0;
  int m_cnt = 0, m_scale = 0;
  bit m_keyq = 0, m_actq = 0;

  always #4 clk_i = ~clk_i;

  osk_amp_ramp dut_i (.*);

  function automatic int exp_sample(input logic [13:0] s, input int sc);
    int p;
    p = int'($signed(s)) * sc;
    return (p >>> 10) & 16'h3FFF;
  endfunction

  task automatic check(input string tag);
    n_vec++;
    if (int'(scale_o) != m_scale) begin
      n_bad++;
      $display("FAIL %s scale actual=%0d expected=%0d", tag, scale_o, m_scale);
    end
    n_vec++;
    if (int'(sample_o) != exp_sample(sample_i, int'(scale_o))) begin
      n_bad++;
      $display("FAIL R9 sample actual=%0h expected=%0h", sample_o, exp_sample(sample_i, int'(scale_o)));
    end
  endtask

  // Model update from the inputs present before the edge, then check after it.
  task automatic cyc(input string tag);
    bit act, frc, tick;
    int step, ceil;
    act  = osk_en_i && auto_en_i;
    frc  = (key_i != m_keyq) || (io_update_i && load_en_i) || (act && !m_actq);
    tick = 0;
    if (act) begin
      if (frc) m_cnt = int'(rate_i);
      else if (m_cnt <= 1) begin m_cnt = int'(rate_i); tick = 1; end
      else m_cnt--;
    end
    if (tick) begin
      step = 1 << amp_reg_i[15:14];
      ceil = int'(amp_reg_i[9:0]);
      if (key_i) m_scale = (m_scale + step > ceil) ? ceil : m_scale + step;
      else       m_scale = (m_scale > step) ? m_scale - step : 0;
    end
    m_keyq = key_i;
    m_actq = act;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    sample_i = 14'h1ABC;
    repeat (3) @(negedge clk_i);
    check("R10");
    rst_ni = 1'b1;

    // R1: only one of the two enables set
    osk_en_i = 1; auto_en_i = 0; key_i = 1; amp_reg_i = 16'h03FF; rate_i = 1;
    for (int i = 0; i < 20; i++) cyc("R1");
    osk_en_i = 0; auto_en_i = 1;
    for (int i = 0; i < 20; i++) cyc("R1");

    // R3: ramp up to a low ceiling with step 8
    osk_en_i = 1; amp_reg_i = 16'hC000 | 16'd300; rate_i = 2;
    for (int i = 0; i < 120; i++) cyc("R3");

    // R4: every step code, up then down
    for (int c = 0; c < 4; c++) begin
      amp_reg_i = (16'(c) << 14) | 16'h03FF; key_i = 1; rate_i = 1;
      for (int i = 0; i < 25; i++) cyc("R4");
      key_i = 0;
      for (int i = 0; i < 25; i++) cyc("R4");
    end

    // R2: ramp to the zero floor with an odd step pattern
    key_i = 1; amp_reg_i = 16'h4000 | 16'd101; rate_i = 0;
    for (int i = 0; i < 60; i++) cyc("R2");
    key_i = 0; amp_reg_i = 16'h8000 | 16'd101; rate_i = 3;
    for (int i = 0; i < 120; i++) cyc("R2");

    // R5: tick periods for rate values 0, 1 and 6
    key_i = 1; amp_reg_i = 16'h03FF;
    foreach (rate_i[j]) ;
    rate_i = 0; for (int i = 0; i < 30; i++) cyc("R5");
    rate_i = 1; for (int i = 0; i < 30; i++) cyc("R5");
    rate_i = 6; for (int i = 0; i < 60; i++) cyc("R5");

    // R6: key toggles landing on and off the terminal count
    rate_i = 4;
    for (int i = 0; i < 80; i++) begin
      if (i % 3 == 0) key_i = ~key_i;
      cyc("R6");
    end

    // R7: update strobes with load enable off, then on
    key_i = 1; rate_i = 5;
    for (int k = 0; k < 2; k++) begin
      load_en_i = k[0];
      for (int i = 0; i < 60; i++) begin
        io_update_i = (i % 4 == 3);
        cyc("R7");
      end
    end
    io_update_i = 0; load_en_i = 0;

    // R8: auto enable toggling
    rate_i = 3;
    for (int i = 0; i < 60; i++) begin
      if (i % 5 == 0) auto_en_i = ~auto_en_i;
      cyc("R8");
    end
    auto_en_i = 1;

    // R9: sample extremes at a held scale
    foreach (sample_i[j]) ;
    osk_en_i = 0;
    sample_i = 14'h1FFF; cyc("R9");
    sample_i = 14'h2000; cyc("R9");
    sample_i = 14'h3FFF; cyc("R9");
    osk_en_i = 1;

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) key_i = ~key_i;
      io_update_i = ($urandom_range(7) == 0);
      if ($urandom_range(3) == 0) load_en_i = $urandom_range(1);
      if ($urandom_range(63) == 0) auto_en_i = ~auto_en_i;
      if ($urandom_range(127) == 0) osk_en_i = ~osk_en_i;
      if ($urandom_range(99) == 0) amp_reg_i = 16'($urandom);
      if ($urandom_range(99) == 0) rate_i = 8'($urandom_range(9));
      sample_i = 14'($urandom);
      cyc("R2/R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule